// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns one active-low external interrupt pin into a held request for the interrupt priority logic. The pin is first brought into the clock domain through a chain of flip-flops. A falling level on the synchronized signal is detected and sets a pending latch. The latch is released by an acknowledge. The acknowledge comes either from the vector-fetch strobe of the processor or from a software write to the control register.

A trigger-mode bit selects how the latch is released. In plain edge mode, an acknowledge alone clears it. In combined edge-and-level mode, the request stays alive while the pin is held low. It is released only once an acknowledge has been seen and the pin is high again, and these two events may happen in either order. A mask bit hides a held request from the priority logic without discarding it.

The synchronized pin level is also brought out, so that branch-on-pin instructions can test it. All pins here are plain control and status signals; none of them carries a data stream.

Top module: `irq_latch_top`

## Requirements
- R1: A high-to-low transition of `pin_level` sets the pending flag (`csr_rdata` bit 3) on the next clock edge, in both trigger modes.
- R2: With the mode bit (`csr_rdata` bit 0) at 0, the pending flag clears on the edge that samples either acknowledge: `vec_fetch_ack` high, or a write with `csr_wdata` bit 2 set. Holding the pin low does not set the flag again.
- R3: With the mode bit at 1, the pending flag stays set while `pin_level` is low, even after an acknowledge. An acknowledge given while the pin is low is remembered. The flag then clears on the edge after `pin_level` returns to 1, with no second acknowledge needed.
- R4: With the mode bit at 1 and `pin_level` already high, an acknowledge clears the pending flag on the edge that samples it.
- R5: Synchronous reset clears the pending flag, the mode bit and the mask bit, even while the pin is held low. A pin that is low when reset is released does not set the flag.
- R6: While the mask bit (`csr_rdata` bit 1) is 1, `irq_req` is 0 and the pending flag is kept. Clearing the mask drives `irq_req` high if the flag is still set.
- R7: Register layout: bit 0 is the mode bit (read/write), bit 1 is the mask bit (read/write), bit 2 is the acknowledge bit (write 1 to acknowledge, always reads 0), bit 3 is the pending flag (read only), and bits 7:4 read 0.
- R8: When a new falling transition and an acknowledge arrive on the same edge, the pending flag stays set.
- R9: `pin_level` follows `irq_pin_n` two clock edges later, and it is 1 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pin_n | input | 1 | Asynchronous external interrupt pin, active low |
| vec_fetch_ack | input | 1 | One-cycle acknowledge from the interrupt vector fetch |
| csr_wr_en | input | 1 | Write strobe for the control register |
| csr_wdata | input | 8 | Write data for the control register |
| csr_rdata | output | 8 | Control and status read value |
| irq_req | output | 1 | Request presented to the priority logic |
| pin_level | output | 1 | Synchronized pin level |

## Verification
A change on the pin shows on `pin_level` after the second rising edge. It reaches the pending flag and `irq_req` after the third edge. An acknowledge or a register write takes effect after the single edge that samples it. In level mode, a release waits for the edge after `pin_level` goes high. The bench changes inputs on the falling clock edge and queues each expected value against a cycle number. A monitor compares the outputs 1 ns after the rising edge that the expected value belongs to.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int CSR_W       = 8;
  localparam int SYNC_STAGES = 2;
  localparam int BIT_MODE    = 0;
  localparam int BIT_MASK    = 1;
  localparam int BIT_ACK     = 2;
  localparam int BIT_PEND    = 3;

  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_latch_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_sync,
  input  trig_mode_e mode,
  input  logic       ack,
  output logic       pending
);
  localparam int ARM_LEN = STAGES + 1;

  logic               prev_q;
  logic [ARM_LEN-1:0] arm_q;
  logic               armed;
  logic               fall;
  logic               pend_q;
  logic               ack_seen_q;

  assign armed = arm_q[ARM_LEN-1];
  assign fall  = armed & prev_q & ~pin_sync;

  // The arm shifter ignores transitions until the chain holds real pin samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      arm_q  <= '0;
    end else begin
      prev_q <= pin_sync;
      arm_q  <= {arm_q[ARM_LEN-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      ack_seen_q <= 1'b0;
    end else if (fall) begin
      pend_q     <= 1'b1;
      ack_seen_q <= 1'b0;
    end else if (pend_q) begin
      if (mode == TRIG_EDGE) begin
        if (ack) pend_q <= 1'b0;
      end else if ((ack || ack_seen_q) && pin_sync) begin
        pend_q     <= 1'b0;
        ack_seen_q <= 1'b0;
      end else if (ack) begin
        ack_seen_q <= 1'b1;
      end
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_latch_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wdata,
  input  logic             pending,
  output trig_mode_e       mode,
  output logic             mask,
  output logic             sw_ack,
  output logic [CSR_W-1:0] rdata
);
  trig_mode_e mode_q;
  logic       mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TRIG_EDGE;
      mask_q <= 1'b0;
    end else if (wr_en) begin
      mode_q <= trig_mode_e'(wdata[BIT_MODE]);
      mask_q <= wdata[BIT_MASK];
    end
  end

  assign sw_ack = wr_en & wdata[BIT_ACK];
  assign mode   = mode_q;
  assign mask   = mask_q;

  always_comb begin
    rdata           = '0;
    rdata[BIT_MODE] = mode_q;
    rdata[BIT_MASK] = mask_q;
    rdata[BIT_PEND] = pending;
  end
endmodule

// File: rtl/irq_latch_top.sv
module irq_latch_top
  import irq_latch_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_pin_n,
  input  logic             vec_fetch_ack,
  input  logic             csr_wr_en,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             irq_req,
  output logic             pin_level
);
  logic       pin_sync;
  logic       pending;
  logic       mask;
  logic       sw_ack;
  trig_mode_e mode;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (irq_pin_n),
    .dout (pin_sync)
  );

  irq_capture #(.STAGES(SYNC_STAGES)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .pin_sync (pin_sync),
    .mode     (mode),
    .ack      (vec_fetch_ack | sw_ack),
    .pending  (pending)
  );

  irq_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (csr_wr_en),
    .wdata   (csr_wdata),
    .pending (pending),
    .mode    (mode),
    .mask    (mask),
    .sw_ack  (sw_ack),
    .rdata   (csr_rdata)
  );

  assign irq_req   = pending & ~mask;
  assign pin_level = pin_sync;
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk
  import irq_latch_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             vec_fetch_ack,
  input logic             csr_wr_en,
  input logic [CSR_W-1:0] csr_wdata,
  input logic [CSR_W-1:0] csr_rdata,
  input logic             irq_req,
  input logic             pin_level
);
  logic lvl_d;
  logic fall_seen;
  logic ack_any;
  logic pend;
  logic mode_b;
  logic mask_b;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b1;
    else     lvl_d <= pin_level;
  end

  assign fall_seen = lvl_d & ~pin_level;
  assign ack_any   = vec_fetch_ack | (csr_wr_en & csr_wdata[BIT_ACK]);
  assign pend      = csr_rdata[BIT_PEND];
  assign mode_b    = csr_rdata[BIT_MODE];
  assign mask_b    = csr_rdata[BIT_MASK];

  // R1: the flag only rises after a falling pin transition
  p_set_by_fall_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(fall_seen));

  // R2: an acknowledge in edge mode clears the flag
  p_edge_ack_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode_b && pend && ack_any && !fall_seen) |=> !pend);

  // R3: a low pin holds the request in level mode
  p_level_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_b && pend && !pin_level) |=> pend);

  // R6: a set mask hides the request
  p_mask_hides_r6: assert property (@(posedge clk) disable iff (rst)
    mask_b |-> !irq_req);

  // R8: a new fall wins over a simultaneous acknowledge
  p_fall_beats_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (pend && fall_seen && ack_any) |=> pend);

  // R7: the acknowledge bit and the upper bits read as zero
  always_comb begin
    if (!rst) begin
      a_read_zero_r7: assert (csr_rdata[BIT_ACK] == 1'b0 && csr_rdata[CSR_W-1:BIT_PEND+1] == '0);
    end
  end
endmodule

bind irq_latch_top irq_latch_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .vec_fetch_ack (vec_fetch_ack),
  .csr_wr_en     (csr_wr_en),
  .csr_wdata     (csr_wdata),
  .csr_rdata     (csr_rdata),
  .irq_req       (irq_req),
  .pin_level     (pin_level)
);

// File: tb/irq_latch_top_test.sv
`timescale 1ns/1ps
module irq_latch_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b1;
  logic       vf = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       irq;
  logic       lvl;

  always #2.5 clk = ~clk;

  irq_latch_top uut (
    .clk           (clk),
    .rst           (rst),
    .irq_pin_n     (pin),
    .vec_fetch_ack (vf),
    .csr_wr_en     (we),
    .csr_wdata     (wd),
    .csr_rdata     (rd),
    .irq_req       (irq),
    .pin_level     (lvl)
  );

  typedef struct {
    int         due;
    logic [7:0] rd;
    logic       irq;
    logic       lvl;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  // Monitor: compares 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk = n_chk + 1;
      if (rd !== e.rd || irq !== e.irq || lvl !== e.lvl) begin
        n_bad = n_bad + 1;
        $display("FAIL %s cycle %0d: rdata=%h irq=%b lvl=%b, expected rdata=%h irq=%b lvl=%b",
                 e.tag, cyc, rd, irq, lvl, e.rd, e.irq, e.lvl);
      end
    end
  end

  // Driver: queue the expected outputs after the next rising edge, then move to the next falling edge
  task automatic step(input string tag, input logic [7:0] erd, input logic eirq, input logic elvl);
    exp_t e;
    e.due = cyc + 1;
    e.rd  = erd;
    e.irq = eirq;
    e.lvl = elvl;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    vf = 1'b0;
    we = 1'b0;
  endtask

  task automatic csr_write(input logic [7:0] v);
    we = 1'b1;
    wd = v;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    step("R5 reset state", 8'h00, 0, 1);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) step("R5 after release", 8'h00, 0, 1);

    // R1/R9: edge mode, the pin falls
    pin = 1'b0;
    step("R9 stage1", 8'h00, 0, 1);
    step("R9 level low", 8'h00, 0, 0);
    step("R1 set", 8'h08, 1, 0);
    // R2: a vector fetch clears, and a held-low pin does not set the flag again
    vf = 1'b1;
    step("R2 vector ack", 8'h00, 0, 0);
    step("R2 no retrigger", 8'h00, 0, 0);
    pin = 1'b1;
    step("R9 rise stage1", 8'h00, 0, 0);
    step("R9 level high", 8'h00, 0, 1);
    step("R2 stays clear", 8'h00, 0, 1);

    // R2/R7: a software acknowledge
    pin = 1'b0;
    step("R1 wait", 8'h00, 0, 1);
    step("R1 wait", 8'h00, 0, 0);
    step("R1 set", 8'h08, 1, 0);
    csr_write(8'h04);
    step("R7 sw ack reads 0", 8'h00, 0, 0);
    pin = 1'b1;
    step("R2 settle", 8'h00, 0, 0);
    step("R2 settle", 8'h00, 0, 1);
    step("R2 settle", 8'h00, 0, 1);

    // R3: level mode, acknowledge while the pin is low
    csr_write(8'h01);
    step("R7 mode bit", 8'h01, 0, 1);
    pin = 1'b0;
    step("R1 wait", 8'h01, 0, 1);
    step("R1 wait", 8'h01, 0, 0);
    step("R1 level-mode set", 8'h09, 1, 0);
    vf = 1'b1;
    step("R3 ack while low", 8'h09, 1, 0);
    step("R3 hold", 8'h09, 1, 0);
    step("R3 hold", 8'h09, 1, 0);
    pin = 1'b1;
    step("R3 rise stage1", 8'h09, 1, 0);
    step("R3 level high", 8'h09, 1, 1);
    step("R3 release", 8'h01, 0, 1);

    // R3/R4: level mode, the pin returns high before the acknowledge
    pin = 1'b0;
    step("R1 wait", 8'h01, 0, 1);
    step("R1 wait", 8'h01, 0, 0);
    step("R1 set", 8'h09, 1, 0);
    pin = 1'b1;
    step("R3 no ack", 8'h09, 1, 0);
    step("R3 no ack", 8'h09, 1, 1);
    step("R3 no ack high", 8'h09, 1, 1);
    csr_write(8'h05);
    step("R4 ack with pin high", 8'h01, 0, 1);

    // R6: masking in edge mode
    csr_write(8'h02);
    step("R6 mask set", 8'h02, 0, 1);
    pin = 1'b0;
    step("R6 wait", 8'h02, 0, 1);
    step("R6 wait", 8'h02, 0, 0);
    step("R6 masked pending", 8'h0A, 0, 0);
    csr_write(8'h00);
    step("R6 unmask presents", 8'h08, 1, 0);
    csr_write(8'h04);
    step("R2 sw clear", 8'h00, 0, 0);
    pin = 1'b1;
    step("settle", 8'h00, 0, 0);
    step("settle", 8'h00, 0, 1);
    step("settle", 8'h00, 0, 1);

    // R8: a new fall on the same edge as an acknowledge
    pin = 1'b0;
    step("R1 wait", 8'h00, 0, 1);
    step("R1 wait", 8'h00, 0, 0);
    step("R1 set", 8'h08, 1, 0);
    pin = 1'b1;
    step("R8 setup", 8'h08, 1, 0);
    step("R8 setup", 8'h08, 1, 1);
    step("R8 setup", 8'h08, 1, 1);
    pin = 1'b0;
    step("R8 setup", 8'h08, 1, 1);
    step("R8 fall pending", 8'h08, 1, 0);
    vf = 1'b1;
    step("R8 fall beats ack", 8'h08, 1, 0);
    vf = 1'b1;
    step("R2 later ack", 8'h00, 0, 0);
    pin = 1'b1;
    step("settle", 8'h00, 0, 0);
    step("settle", 8'h00, 0, 1);
    step("settle", 8'h00, 0, 1);

    // R5: reset in level mode while the pin is held low
    csr_write(8'h01);
    step("R7 mode bit", 8'h01, 0, 1);
    pin = 1'b0;
    step("R1 wait", 8'h01, 0, 1);
    step("R1 wait", 8'h01, 0, 0);
    step("R1 set", 8'h09, 1, 0);
    rst = 1'b1;
    step("R5 reset clears", 8'h00, 0, 1);
    step("R9 level in reset", 8'h00, 0, 1);
    rst = 1'b0;
    step("R5 release", 8'h00, 0, 1);
    step("R5 release low", 8'h00, 0, 0);
    for (int i = 0; i < 3; i++) step("R5 no spurious set", 8'h00, 0, 0);
    pin = 1'b1;
    step("settle", 8'h00, 0, 0);
    step("settle", 8'h00, 0, 1);
    step("settle", 8'h00, 0, 1);
    pin = 1'b0;
    step("R1 wait", 8'h00, 0, 1);
    step("R1 wait", 8'h00, 0, 0);
    step("R1 after reset", 8'h08, 1, 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule